// File: doc/BRIEF.md
# BCD Calendar Register Bank

This block keeps wall-clock time and calendar date in packed BCD and shows them to software as eight byte registers at the top of an 11-bit byte address space. Time is held in internal counters that advance on a one-cycle pulse arriving once per second. The eight visible bytes are a separate copy. One cycle after each pulse, all seven time fields are copied from the counters together.

Software reads and writes the window through a synchronous byte bus with separate read and write strobes. Two control flags stop the copying. The hold-for-read flag freezes a consistent snapshot while time keeps running. The hold-for-set flag freezes the bytes so new values can be entered; clearing it loads all seven edited bytes into the counters in a single cycle. A halt flag inside the seconds byte stops the counters. A test flag inside the weekday byte replaces the lowest seconds bit with an external 512 Hz test level on reads. Software may change both flags at any time, without the hold-for-set flag.

Top module: `rtc_regbank`

## Requirements
- R1: The window is byte addresses 0x7F8 (control), 0x7F9 (seconds), 0x7FA (minutes), 0x7FB (hours), 0x7FC (weekday), 0x7FD (date), 0x7FE (month) and 0x7FF (year). Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high, and holds until the next read.
- R2: All fields are packed BCD. Seconds and minutes wrap 59 to 00, hours (24-hour) wrap 23 to 00, and the weekday runs 1 to 7 and steps 7 to 1 at midnight. The year wraps 99 to 00.
- R3: The date wraps after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. February ends at 29 when the two-digit year is divisible by four, and at 28 otherwise. The month wraps 12 to 01 and then increments the year.
- R4: The cycle after a seconds pulse, the seven time bytes are updated together from the counters.
- R5: Control bit 6 (hold-for-read), while 1, freezes the visible bytes and lets the counters run. A copy that is due in the same cycle as the write setting the bit still takes place. After the bit is cleared, the next pulse shows the running time.
- R6: Control bit 7 (hold-for-set), while 1, freezes the visible bytes. Writing the control byte with bit 7 at 0 while it is 1 loads bytes 0x7F9 to 0x7FF into the counters.
- R7: Seconds bit 7 is the halt flag. It comes out of reset as 1, and while it is 1 the counters do not advance.
- R8: Weekday bit 6 is the test flag. While it is 1, bit 0 of a seconds read returns the level of `test_512`.
- R9: The halt and test flags take effect on a direct write to their bytes, with the control byte at 0.
- R10: Bits outside the fields read as 0: control bits 5:0, minutes bit 7, hours bits 7:6, weekday bits 7 and 5:3, date bits 7:6, month bits 7:5.
- R11: Writes to addresses below 0x7F8 change nothing in the window, and reads from them return 0x00.
- R12: After reset the visible time and the counters are 00:00:00, weekday 1, date 01, month 01, year 00, with both control flags and the test flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid one cycle after `bus_rd` |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| test_512 | input | 1 | 512 Hz test level shown in seconds bit 0 under the test flag |

## Verification
The counter range checks assume that software loads only valid BCD values through the hold-for-set sequence. The bench never clears the hold-for-set flag while an out-of-range byte is still in the window, and it rewrites every field before each load. The properties also assume that `tick_1hz` is high for a single cycle and that read and write strobes never overlap. The bench drives each strobe for one cycle, leaves an idle cycle between accesses, and spaces the pulses by at least three cycles. One exception is deliberate: a control write is placed in the copy cycle to exercise the copy that is already due when the hold is set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] sec;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] dow;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] mon;
        logic [BYTE_W-1:0] year;
    } rtc_time_t;

    localparam rtc_time_t TIME_RST = '{
        sec: 8'h00, min: 8'h00, hour: 8'h00, dow: 8'h01,
        date: 8'h01, mon: 8'h01, year: 8'h00
    };

    // add one to a two-digit BCD value (caller handles the top wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] >= 4'd9) begin
            return {b[7:4] + 4'd1, 4'd0};
        end
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

    // two-digit BCD year divisible by four
    function automatic logic bcd_leap(input logic [7:0] y);
        if (y[4]) begin
            return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        end
        return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic rtc_time_t time_step(input rtc_time_t t);
        rtc_time_t n;
        n = t;
        if (t.sec != 8'h59) begin
            n.sec = bcd_inc(t.sec);
        end else begin
            n.sec = 8'h00;
            if (t.min != 8'h59) begin
                n.min = bcd_inc(t.min);
            end else begin
                n.min = 8'h00;
                if (t.hour != 8'h23) begin
                    n.hour = bcd_inc(t.hour);
                end else begin
                    n.hour = 8'h00;
                    n.dow  = (t.dow == 8'h07) ? 8'h01 : bcd_inc(t.dow);
                    if (t.date != month_end(t.mon, t.year)) begin
                        n.date = bcd_inc(t.date);
                    end else begin
                        n.date = 8'h01;
                        if (t.mon != 8'h12) begin
                            n.mon = bcd_inc(t.mon);
                        end else begin
                            n.mon  = 8'h01;
                            n.year = (t.year == 8'h99) ? 8'h00 : bcd_inc(t.year);
                        end
                    end
                end
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      halt_i,
    input  logic      load_i,
    input  rtc_time_t load_val_i,
    output rtc_time_t time_o,
    output logic      upd_o
);

    typedef struct packed {
        rtc_time_t t;
        logic      upd;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = tick_i;
        if (load_i) begin
            st_d.t = load_val_i;
        end else if (tick_i && !halt_i) begin
            st_d.t = time_step(st_q.t);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.t   <= TIME_RST;
            st_q.upd <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign time_o = st_q.t;
    assign upd_o  = st_q.upd;

endmodule

// File: rtl/rtc_view_regs.sv
module rtc_view_regs
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic              test_i,
    input  logic              upd_i,
    input  rtc_time_t         cnt_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              halt_o,
    output logic              load_o,
    output rtc_time_t         load_val_o,
    output rtc_time_t         vis_o,
    output logic              frozen_o
);

    localparam int SEL_W = 3;

    typedef struct packed {
        rtc_time_t         vis;
        logic              hold_set;
        logic              hold_rd;
        logic              halt;
        logic              ftest;
        logic [BYTE_W-1:0] rdata;
    } view_state_t;

    view_state_t st_d, st_q;

    logic             in_win;
    logic [SEL_W-1:0] sel;
    logic [BYTE_W-1:0] rd_val;

    assign in_win = &addr_i[ADDR_W-1:SEL_W];
    assign sel    = addr_i[SEL_W-1:0];

    always_comb begin
        case (sel)
            3'd0:    rd_val = {st_q.hold_set, st_q.hold_rd, 6'b0};
            3'd1:    rd_val = {st_q.halt, st_q.vis.sec[6:1],
                               st_q.ftest ? test_i : st_q.vis.sec[0]};
            3'd2:    rd_val = st_q.vis.min;
            3'd3:    rd_val = st_q.vis.hour;
            3'd4:    rd_val = {1'b0, st_q.ftest, st_q.vis.dow[5:0]};
            3'd5:    rd_val = st_q.vis.date;
            3'd6:    rd_val = st_q.vis.mon;
            default: rd_val = st_q.vis.year;
        endcase
    end

    always_comb begin
        st_d   = st_q;
        load_o = 1'b0;
        if (upd_i && !st_q.hold_rd && !st_q.hold_set) begin
            st_d.vis = cnt_i;
        end
        if (wr_i && in_win) begin
            case (sel)
                3'd0: begin
                    st_d.hold_set = wdata_i[7];
                    st_d.hold_rd  = wdata_i[6];
                    load_o        = st_q.hold_set && !wdata_i[7];
                end
                3'd1: begin
                    st_d.halt    = wdata_i[7];
                    st_d.vis.sec = {1'b0, wdata_i[6:0]};
                end
                3'd2: st_d.vis.min  = {1'b0, wdata_i[6:0]};
                3'd3: st_d.vis.hour = {2'b0, wdata_i[5:0]};
                3'd4: begin
                    st_d.ftest   = wdata_i[6];
                    st_d.vis.dow = {5'b0, wdata_i[2:0]};
                end
                3'd5: st_d.vis.date = {2'b0, wdata_i[5:0]};
                3'd6: st_d.vis.mon  = {3'b0, wdata_i[4:0]};
                default: st_d.vis.year = wdata_i;
            endcase
        end
        if (rd_i) begin
            st_d.rdata = in_win ? rd_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vis      <= TIME_RST;
            st_q.hold_set <= 1'b0;
            st_q.hold_rd  <= 1'b0;
            st_q.halt     <= 1'b1;
            st_q.ftest    <= 1'b0;
            st_q.rdata    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o    = st_q.rdata;
    assign halt_o     = st_q.halt;
    assign load_val_o = st_q.vis;
    assign vis_o      = st_q.vis;
    assign frozen_o   = st_q.hold_rd || st_q.hold_set;

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    input  logic              tick_1hz,
    input  logic              test_512
);

    rtc_time_t cnt_time;
    rtc_time_t vis_time;
    rtc_time_t load_val;
    logic      upd;
    logic      halt;
    logic      load;
    logic      frozen;

    rtc_time_counter u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_1hz),
        .halt_i     (halt),
        .load_i     (load),
        .load_val_i (load_val),
        .time_o     (cnt_time),
        .upd_o      (upd)
    );

    rtc_view_regs #(
        .ADDR_W (ADDR_W)
    ) u_view (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .rd_i       (bus_rd),
        .wr_i       (bus_wr),
        .test_i     (test_512),
        .upd_i      (upd),
        .cnt_i      (cnt_time),
        .rdata_o    (bus_rdata),
        .halt_o     (halt),
        .load_o     (load),
        .load_val_o (load_val),
        .vis_o      (vis_time),
        .frozen_o   (frozen)
    );

endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input rtc_time_t         cnt_time,
    input rtc_time_t         vis_time,
    input logic              upd,
    input logic              halt,
    input logic              load,
    input logic              frozen
);

    localparam logic [ADDR_W-1:0] WIN_LO = {{(ADDR_W-3){1'b1}}, 3'b000};

    logic win_acc;
    logic time_wr;
    assign win_acc = bus_addr >= WIN_LO;
    assign time_wr = bus_wr && win_acc && (bus_addr != WIN_LO);

    // R2: counters stay inside the BCD ranges
    a_r2_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_time.sec <= 8'h59 && cnt_time.sec[3:0] <= 4'd9);
    a_r2_hour_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_time.hour <= 8'h23 && cnt_time.hour[3:0] <= 4'd9);

    // R4: copy lands as one step
    a_r4_copy_whole: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !frozen && !time_wr) |=> (vis_time == $past(cnt_time)));

    // R4, R11: no copy and no window write leaves the bytes alone
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !(bus_wr && win_acc)) |=> $stable(vis_time));

    // R6: clearing the set flag loads the counters
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_time == $past(vis_time)));

    // R7: halted counters do not move
    a_r7_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> $stable(cnt_time));

    // R10: unused control bits read zero
    a_r10_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == WIN_LO) |=> (bus_rdata[5:0] == 6'd0));

    // R11: reads below the window return zero
    a_r11_low_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !win_acc) |=> (bus_rdata == 8'h00));

endmodule

bind rtc_regbank rtc_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .cnt_time  (cnt_time),
    .vis_time  (vis_time),
    .upd       (upd),
    .halt      (halt),
    .load      (load),
    .frozen    (frozen)
);

// File: tb/test_rtc_regbank.sv
`timescale 1ns/1ps
module test_rtc_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        tick_1hz = 1'b0;
    logic        test_512 = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench time model (binary)
    int ms, mm, mh, mdw, mdt, mmo, myr;
    bit halt_m = 1'b1;
    bit ft_m = 1'b0;

    always #10 clk = ~clk;

    rtc_regbank i_rtc_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .tick_1hz  (tick_1hz),
        .test_512  (test_512)
    );

    function automatic logic [7:0] bcd(int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int dim(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic m_adv();
        if (halt_m) return;
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0;
                    mdw = (mdw == 7) ? 1 : mdw + 1;
                    mdt++;
                    if (mdt > dim(mmo, myr)) begin
                        mdt = 1; mmo++;
                        if (mmo == 13) begin
                            mmo = 1;
                            myr = (myr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(logic [10:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        @(negedge clk);
        m_adv();
    endtask

    function automatic logic [7:0] exp_sec();
        logic [7:0] b;
        b = bcd(ms);
        return {halt_m, b[6:1], ft_m ? test_512 : b[0]};
    endfunction

    task automatic check_all(string req);
        logic [7:0] d;
        brd(11'h7F9, d); chk({req, " sec"}, d, exp_sec());
        brd(11'h7FA, d); chk({req, " min"}, d, bcd(mm));
        brd(11'h7FB, d); chk({req, " hour"}, d, bcd(mh));
        brd(11'h7FC, d); chk({req, " dow"}, d, bcd(mdw) | {1'b0, ft_m, 6'b0});
        brd(11'h7FD, d); chk({req, " date"}, d, bcd(mdt));
        brd(11'h7FE, d); chk({req, " month"}, d, bcd(mmo));
        brd(11'h7FF, d); chk({req, " year"}, d, bcd(myr));
    endtask

    // R6 load sequence
    task automatic set_time(int s, int m, int h, int dw, int dt, int mo, int yr);
        bwr(11'h7F8, 8'h80);
        bwr(11'h7F9, bcd(s) | {halt_m, 7'b0});
        bwr(11'h7FA, bcd(m));
        bwr(11'h7FB, bcd(h));
        bwr(11'h7FC, bcd(dw) | {1'b0, ft_m, 6'b0});
        bwr(11'h7FD, bcd(dt));
        bwr(11'h7FE, bcd(mo));
        bwr(11'h7FF, bcd(yr));
        bwr(11'h7F8, 8'h00);
        ms = s; mm = m; mh = h; mdw = dw; mdt = dt; mmo = mo; myr = yr;
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] snap;
        ms = 0; mm = 0; mh = 0; mdw = 1; mdt = 1; mmo = 1; myr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state, R1 read path
        brd(11'h7F8, d); chk("R12 ctrl", d, 8'h00);
        check_all("R12 R1");

        // R7 halted after reset
        tick();
        brd(11'h7F9, d); chk("R7 halted sec", d, 8'h80);

        // R9 clear halt by direct write, counting resumes
        bwr(11'h7F9, 8'h00);
        halt_m = 1'b0;
        tick();
        check_all("R9 R7 run");

        // R2 sweep across midnight, weekday 7->1, year 99->00
        set_time(0, 58, 23, 7, 31, 12, 99);
        for (int i = 0; i < 130; i++) begin
            tick();
            check_all("R2 R4 sweep");
        end

        // R3 month ends over leap and common years
        foreach (myr_list[k]) begin
            for (int mo = 1; mo <= 12; mo++) begin
                set_time(59, 59, 23, 3, dim(mo, myr_list[k]), mo, myr_list[k]);
                tick();
                check_all("R3 month end");
            end
        end
        set_time(59, 59, 23, 2, 28, 2, 24);
        tick();
        check_all("R3 leap 28");

        // R7 halt holds counters, then resumes
        set_time(10, 0, 12, 4, 10, 5, 40);
        bwr(11'h7F9, bcd(ms) | 8'h80);
        halt_m = 1'b1;
        tick(); tick();
        check_all("R7 halt set");
        bwr(11'h7F9, bcd(ms));
        halt_m = 1'b0;
        tick();
        check_all("R7 halt clear");

        // R5 hold-for-read freezes view while counters run
        snap = bcd(ms);
        bwr(11'h7F8, 8'h40);
        brd(11'h7F8, d); chk("R5 ctrl readback", d, 8'h40);
        tick(); tick(); tick();
        brd(11'h7F9, d); chk("R5 frozen sec", d, snap);
        bwr(11'h7F8, 8'h00);
        tick();
        check_all("R5 resume");

        // R5 copy due in same cycle as the hold write completes
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        bus_addr = 11'h7F8; bus_wdata = 8'h40; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_adv();
        snap = bcd(ms);
        brd(11'h7F9, d); chk("R5 copy completes", d, snap);
        tick();
        brd(11'h7F9, d); chk("R5 held after", d, snap);
        bwr(11'h7F8, 8'h00);
        tick();
        check_all("R5 resume 2");

        // R6 hold-for-set freezes, then load
        snap = bcd(ms);
        bwr(11'h7F8, 8'h80);
        tick();
        brd(11'h7F9, d); chk("R6 frozen sec", d, snap);
        set_time(56, 34, 12, 2, 15, 6, 30);
        check_all("R6 loaded");
        tick();
        check_all("R6 loaded run");

        // R8 R9 test flag by direct weekday write
        bwr(11'h7FC, bcd(mdw) | 8'h40);
        ft_m = 1'b1;
        test_512 = 1'b1;
        brd(11'h7F9, d); chk("R8 test high", d, exp_sec());
        test_512 = 1'b0;
        brd(11'h7F9, d); chk("R8 test low", d, exp_sec());
        brd(11'h7FC, d); chk("R9 test flag", d, bcd(mdw) | 8'h40);
        bwr(11'h7FC, bcd(mdw));
        ft_m = 1'b0;
        check_all("R8 test off");

        // R10 unused bits read zero
        bwr(11'h7F8, 8'hFF);
        brd(11'h7F8, d); chk("R10 ctrl", d, 8'hC0);
        bwr(11'h7FA, 8'hFF);
        brd(11'h7FA, d); chk("R10 min", d, 8'h7F);
        bwr(11'h7FB, 8'hFF);
        brd(11'h7FB, d); chk("R10 hour", d, 8'h3F);
        bwr(11'h7FC, 8'hFF);
        brd(11'h7FC, d); chk("R10 dow", d, 8'h47);
        bwr(11'h7FD, 8'hFF);
        brd(11'h7FD, d); chk("R10 date", d, 8'h3F);
        bwr(11'h7FE, 8'hFF);
        brd(11'h7FE, d); chk("R10 month", d, 8'h1F);
        ft_m = 1'b0;
        set_time(30, 45, 9, 5, 20, 8, 51);
        check_all("R10 restore");

        // R11 low addresses ignored
        bwr(11'h000, 8'hFF);
        bwr(11'h7F7, 8'hFF);
        bwr(11'h7F0, 8'hC0);
        bwr(11'h7F1, 8'h80);
        brd(11'h7F7, d); chk("R11 read 7F7", d, 8'h00);
        brd(11'h100, d); chk("R11 read 100", d, 8'h00);
        check_all("R11 unchanged");
        tick();
        check_all("R11 not frozen");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    int myr_list[4] = '{23, 24, 0, 1};

endmodule